// File: doc/BRIEF.md
# Linkable Down-Counter Timer Pair

This block holds two terminal-count timers on one system clock: a narrow low timer (24 bits by default) and a wide high timer (32 bits by default). Each timer has a setting value, a live observation value, a control word and a clock-rate choice. A shared prescaler makes four tick rates from the system clock. Each timer steps only on the tick it has chosen. On its own, each timer counts down. At terminal count it reloads its setting value and raises a sticky status flag. The flag drives that timer's interrupt output when the matching enable bit is set.

A link bit in the low timer's control word joins the two timers into one wide free-running counter. In this mode the low timer still counts down. Each low terminal event carries into the high timer, which counts upward from the bitwise inverse of its setting value. When the high timer overflows, it reloads that inverse and raises its own flag. Software reaches every field through a simple synchronous register port: a one-cycle write strobe with address and data, and a combinational read.

Top module: `tmr_pair`

## Requirements
- R1: After synchronous reset, every register, counter and flag is zero. Every readable address returns 0, and both interrupt outputs are low.
- R2: In standalone mode, an enabled timer counts down by one on each tick of its selected rate. The tick that finds the count at 0 reloads the setting value and sets that timer's status flag. A period therefore lasts setting+1 ticks. The low setting register is at address 0x0 and keeps only bits 23:0; the others read as 0. The low observation register is at 0x3. The high setting register is at 0x4 and the high observation register is at 0x7, both 32 bits.
- R3: The control words are at 0x1 (low) and 0x5 (high). Bit 0 is the enable. Writing 1 to bit 1 loads the counter from its setting value on that write's clock edge; bit 1 always reads back 0. While the enable is 0, the counter holds its value and sets no flag.
- R4: A write to a setting register does not change the running count. The new value enters the counter only at the next reload or restart.
- R5: The rate selects are at 0x2 (low) and 0x6 (high), bits 1:0. Code 0 ticks once every DIV_FAST cycles (8 MHz class), code 1 every DIV_K32 cycles (32.768 kHz class), code 2 every DIV_K1 cycles (1.024 kHz class) and code 3 every DIV_SLOW cycles (32 Hz class).
- R6: Bit 3 of the low control word links the pair and reads back as written. A low restart written with bit 3 set also loads the high counter with the bitwise inverse of the high setting value. For example, with low setting 0xFFFFF8 and high setting 0x000007FF, the observation registers read 0xFFFFF8 and 0xFFFFF800.
- R7: In linked mode, each low terminal event reloads the low timer and sets the low flag. If the high timer is enabled, the same event also increments the high counter by one. The high timer then ignores its own rate select.
- R8: In linked mode, a carry that finds the high counter at all ones reloads it with the inverse of the high setting value and sets the high flag. This happens on the same edge that sets the low flag.
- R9: The status register is at 0x8: bit 0 is the low flag and bit 1 the high flag. A flag stays set until software writes 1 to its bit. A terminal event on the same edge as such a clear leaves the flag set.
- R10: The interrupt enable register is at 0x9: bit 0 for low, bit 1 for high. irq_lo and irq_hi are high exactly when the matching flag and enable bit are both 1.
- R11: Reading any address changes no counter and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by the prescaler and both timers |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_lo | output | 1 | Low timer interrupt |
| irq_hi | output | 1 | High timer interrupt |

## Verification
In linked mode, the low terminal event and the high overflow fall on the same clock edge. The bench chooses settings so that the carry finds the high counter at all ones, and then expects both status bits to appear together. A second collision is a software clear of the status register on the very edge where the low timer reaches terminal count. The bench times that write by cycle counting and expects the low flag to survive while the high flag, which had no new event, clears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 32;
  localparam int unsigned NSRC = 4;
  localparam int unsigned NTMR = 2;

  typedef enum logic [AW-1:0] {
    A_LO_SET  = 4'h0,
    A_LO_CTRL = 4'h1,
    A_LO_SRC  = 4'h2,
    A_LO_OBS  = 4'h3,
    A_HI_SET  = 4'h4,
    A_HI_CTRL = 4'h5,
    A_HI_SRC  = 4'h6,
    A_HI_OBS  = 4'h7,
    A_STAT    = 4'h8,
    A_IEN     = 4'h9
  } reg_addr_e;

  // control word bit positions
  localparam int unsigned CB_EN      = 0;
  localparam int unsigned CB_RESTART = 1;
  localparam int unsigned CB_LINK    = 3;

  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_K32  = 2'd1,
    SRC_K1   = 2'd2,
    SRC_SLOW = 2'd3
  } src_e;

  // flag / enable bit index per timer
  localparam int unsigned T_LO = 0;
  localparam int unsigned T_HI = 1;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned DIV_FAST = 1,
  parameter int unsigned DIV_K32  = 3,
  parameter int unsigned DIV_K1   = 6,
  parameter int unsigned DIV_SLOW = 12
) (
  input  logic            clk,
  input  logic            rst,
  output logic [NSRC-1:0] tick
);
  function automatic int unsigned div_of(input int unsigned idx);
    case (idx)
      0:       return DIV_FAST;
      1:       return DIV_K32;
      2:       return DIV_K1;
      default: return DIV_SLOW;
    endcase
  endfunction

  for (genvar g = 0; g < NSRC; g++) begin : g_rate
    localparam int unsigned D  = div_of(g);
    localparam int unsigned CW = (D > 1) ? $clog2(D) : 1;
    logic [CW-1:0] phase_q;
    logic          wrap;

    assign wrap = (phase_q == CW'(D - 1));

    always_ff @(posedge clk) begin
      if (rst)       phase_q <= '0;
      else if (wrap) phase_q <= '0;
      else           phase_q <= phase_q + CW'(1);
    end

    assign tick[g] = wrap;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load,
  input  logic         up,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] wrap_val,
  output logic [W-1:0] count,
  output logic         term
);
  function automatic logic at_end(input logic [W-1:0] v, input logic dir_up);
    return dir_up ? (&v) : (v == '0);
  endfunction

  function automatic logic [W-1:0] advance(input logic [W-1:0] v, input logic dir_up);
    return dir_up ? (v + W'(1)) : (v - W'(1));
  endfunction

  logic [W-1:0] cnt_q;
  logic         end_hit;

  assign end_hit = at_end(cnt_q, up);
  assign term    = step & end_hit & ~load;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (step) cnt_q <= end_hit ? wrap_val : advance(cnt_q, up);
  end

  assign count = cnt_q;
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_q;

  // a new event outranks a clear on the same edge
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr) | set;
  end

  assign flags = flags_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int unsigned LO_W     = 24,
  parameter int unsigned HI_W     = 32,
  parameter int unsigned DIV_FAST = 1,
  parameter int unsigned DIV_K32  = 3,
  parameter int unsigned DIV_K1   = 6,
  parameter int unsigned DIV_SLOW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_lo,
  output logic          irq_hi
);
  // register state
  logic [LO_W-1:0] lo_set_q;
  logic [HI_W-1:0] hi_set_q;
  logic            lo_en_q, hi_en_q, link_q;
  src_e            lo_src_q, hi_src_q;
  logic [NTMR-1:0] ien_q;

  // named internal events
  logic [NSRC-1:0] tick;
  logic            wr_lo_ctrl, wr_hi_ctrl;
  logic            lo_load, hi_load, link_next;
  logic            lo_step, hi_step, lo_term, hi_term, carry;
  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt, hi_inv_set, hi_load_val, hi_wrap_val;
  logic [NTMR-1:0] flags, stat_set, stat_clr;

  tmr_prescaler #(
    .DIV_FAST(DIV_FAST), .DIV_K32(DIV_K32), .DIV_K1(DIV_K1), .DIV_SLOW(DIV_SLOW)
  ) i_presc (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  // write decode
  assign wr_lo_ctrl = reg_wr && (reg_addr == A_LO_CTRL);
  assign wr_hi_ctrl = reg_wr && (reg_addr == A_HI_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_set_q <= '0;
      hi_set_q <= '0;
      lo_en_q  <= 1'b0;
      hi_en_q  <= 1'b0;
      link_q   <= 1'b0;
      lo_src_q <= SRC_FAST;
      hi_src_q <= SRC_FAST;
      ien_q    <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_LO_SET:  lo_set_q <= reg_wdata[LO_W-1:0];
        A_HI_SET:  hi_set_q <= reg_wdata[HI_W-1:0];
        A_LO_CTRL: begin
          lo_en_q <= reg_wdata[CB_EN];
          link_q  <= reg_wdata[CB_LINK];
        end
        A_HI_CTRL: hi_en_q  <= reg_wdata[CB_EN];
        A_LO_SRC:  lo_src_q <= src_e'(reg_wdata[1:0]);
        A_HI_SRC:  hi_src_q <= src_e'(reg_wdata[1:0]);
        A_IEN:     ien_q    <= reg_wdata[NTMR-1:0];
        default:   ;
      endcase
    end
  end

  // restart and link handling
  assign link_next   = wr_lo_ctrl ? reg_wdata[CB_LINK] : link_q;
  assign lo_load     = wr_lo_ctrl & reg_wdata[CB_RESTART];
  assign hi_load     = (wr_hi_ctrl & reg_wdata[CB_RESTART]) |
                       (lo_load & reg_wdata[CB_LINK]);
  assign hi_inv_set  = ~hi_set_q;
  assign hi_load_val = link_next ? hi_inv_set : hi_set_q;
  assign hi_wrap_val = link_q    ? hi_inv_set : hi_set_q;

  // stepping
  assign lo_step = lo_en_q & tick[lo_src_q];
  assign carry   = link_q & lo_term;
  assign hi_step = hi_en_q & (link_q ? carry : tick[hi_src_q]);

  tmr_counter #(.W(LO_W)) i_lo (
    .clk     (clk),
    .rst     (rst),
    .step    (lo_step),
    .load    (lo_load),
    .up      (1'b0),
    .load_val(lo_set_q),
    .wrap_val(lo_set_q),
    .count   (lo_cnt),
    .term    (lo_term)
  );

  tmr_counter #(.W(HI_W)) i_hi (
    .clk     (clk),
    .rst     (rst),
    .step    (hi_step),
    .load    (hi_load),
    .up      (link_q),
    .load_val(hi_load_val),
    .wrap_val(hi_wrap_val),
    .count   (hi_cnt),
    .term    (hi_term)
  );

  // status flags
  assign stat_set = {hi_term, lo_term};
  assign stat_clr = (reg_wr && (reg_addr == A_STAT)) ? reg_wdata[NTMR-1:0] : '0;

  tmr_flags #(.N(NTMR)) i_flags (
    .clk  (clk),
    .rst  (rst),
    .set  (stat_set),
    .clr  (stat_clr),
    .flags(flags)
  );

  assign irq_lo = flags[T_LO] & ien_q[T_LO];
  assign irq_hi = flags[T_HI] & ien_q[T_HI];

  // read path
  always_comb begin
    case (reg_addr)
      A_LO_SET:  reg_rdata = DW'(lo_set_q);
      A_LO_CTRL: reg_rdata = DW'({link_q, 2'b00, lo_en_q});
      A_LO_SRC:  reg_rdata = DW'(lo_src_q);
      A_LO_OBS:  reg_rdata = DW'(lo_cnt);
      A_HI_SET:  reg_rdata = DW'(hi_set_q);
      A_HI_CTRL: reg_rdata = DW'(hi_en_q);
      A_HI_SRC:  reg_rdata = DW'(hi_src_q);
      A_HI_OBS:  reg_rdata = DW'(hi_cnt);
      A_STAT:    reg_rdata = DW'(flags);
      A_IEN:     reg_rdata = DW'(ien_q);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int unsigned LO_W = 24,
  parameter int unsigned HI_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [LO_W-1:0] lo_cnt,
  input logic [HI_W-1:0] hi_cnt,
  input logic [LO_W-1:0] lo_set,
  input logic [HI_W-1:0] hi_set,
  input logic            lo_en,
  input logic            hi_en,
  input logic            link,
  input logic            lo_load,
  input logic            hi_load,
  input logic            lo_term,
  input logic            hi_term,
  input logic [1:0]      flags,
  input logic [1:0]      stat_clr,
  input logic [1:0]      ien,
  input logic            irq_hi
);
  AST_LO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    lo_term |=> lo_cnt == $past(lo_set)); // R2

  AST_LO_FLAG: assert property (@(posedge clk) disable iff (rst)
    lo_term |=> flags[0]); // R2

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!lo_en && !lo_load) |=> $stable(lo_cnt)); // R3

  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (rst)
    lo_load |=> lo_cnt == $past(lo_set)); // R3

  AST_CARRY_INC: assert property (@(posedge clk) disable iff (rst)
    (link && hi_en && lo_term && !hi_load && !(&hi_cnt))
      |=> hi_cnt == HI_W'($past(hi_cnt) + 1'b1)); // R7

  AST_HI_WRAP: assert property (@(posedge clk) disable iff (rst)
    (link && hi_en && lo_term && !hi_load && (&hi_cnt))
      |=> hi_cnt == ~$past(hi_set)); // R8

  AST_HI_FLAG: assert property (@(posedge clk) disable iff (rst)
    hi_term |=> flags[1]); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flags[0] && !stat_clr[0]) |=> flags[0]); // R9

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> ien[1]); // R10
endmodule

bind tmr_pair tmr_pair_chk #(.LO_W(LO_W), .HI_W(HI_W)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .lo_cnt  (lo_cnt),
  .hi_cnt  (hi_cnt),
  .lo_set  (lo_set_q),
  .hi_set  (hi_set_q),
  .lo_en   (lo_en_q),
  .hi_en   (hi_en_q),
  .link    (link_q),
  .lo_load (lo_load),
  .hi_load (hi_load),
  .lo_term (lo_term),
  .hi_term (hi_term),
  .flags   (flags),
  .stat_clr(stat_clr),
  .ien     (ien_q),
  .irq_hi  (irq_hi)
);

// File: tb/test_tmr_pair.sv
module test_tmr_pair;
  localparam int unsigned D0 = 1, D1 = 3, D2 = 6, D3 = 12;

  // own names for the register addresses
  localparam logic [3:0] LS = 4'h0, LC = 4'h1, LSRC = 4'h2, LO = 4'h3;
  localparam logic [3:0] HS = 4'h4, HC = 4'h5, HO = 4'h7, ST = 4'h8, IE = 4'h9;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_I = 2'd2, OP_P = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 71;
  localparam vec_t TBL [NV] = '{
    '{OP_W, LS, 32'h5, 4'd2},          // R2 low setting
    '{OP_W, LC, 32'h3, 4'd3},          // R3 enable + restart
    '{OP_R, LO, 32'h5, 4'd3},
    '{OP_R, LC, 32'h1, 4'd3},          // restart bit reads 0
    '{OP_I, LS, 32'd3, 4'd2},
    '{OP_R, LO, 32'h2, 4'd2},          // R2 down count
    '{OP_R, LO, 32'h2, 4'd11},         // R11 read again, unchanged
    '{OP_W, LS, 32'h9, 4'd4},          // R4 new setting while running
    '{OP_R, LO, 32'h1, 4'd4},
    '{OP_I, LS, 32'd1, 4'd2},
    '{OP_R, ST, 32'h0, 4'd2},
    '{OP_I, LS, 32'd1, 4'd2},
    '{OP_R, LO, 32'h9, 4'd4},          // reload takes new setting
    '{OP_R, ST, 32'h1, 4'd2},
    '{OP_W, ST, 32'h1, 4'd9},          // R9 write-1 clear
    '{OP_R, ST, 32'h0, 4'd9},
    '{OP_W, LC, 32'h2, 4'd3},          // restart, disabled
    '{OP_I, LS, 32'd5, 4'd3},
    '{OP_R, LO, 32'h9, 4'd3},          // R3 held
    '{OP_R, ST, 32'h0, 4'd3},
    '{OP_W, LS, 32'hABCDEF12, 4'd2},
    '{OP_R, LS, 32'h00CDEF12, 4'd2},   // 24-bit setting
    '{OP_W, HS, 32'h3, 4'd2},
    '{OP_W, HC, 32'h3, 4'd2},
    '{OP_I, LS, 32'd3, 4'd2},
    '{OP_R, HO, 32'h0, 4'd2},
    '{OP_I, LS, 32'd1, 4'd2},
    '{OP_R, HO, 32'h3, 4'd2},
    '{OP_R, ST, 32'h2, 4'd2},
    '{OP_W, HC, 32'h0, 4'd3},
    '{OP_W, ST, 32'h3, 4'd9},
    '{OP_R, ST, 32'h0, 4'd9},
    '{OP_W, LS, 32'hFFFFF8, 4'd6},     // R6 link example
    '{OP_W, HS, 32'h7FF, 4'd6},
    '{OP_W, LC, 32'h0A, 4'd6},
    '{OP_R, LO, 32'hFFFFF8, 4'd6},
    '{OP_R, HO, 32'hFFFFF800, 4'd6},
    '{OP_R, LC, 32'h8, 4'd6},
    '{OP_W, HS, 32'h1, 4'd7},          // R7 carry chain
    '{OP_W, LS, 32'h2, 4'd7},
    '{OP_W, LC, 32'h0A, 4'd7},
    '{OP_W, IE, 32'h1, 4'd10},
    '{OP_W, HC, 32'h1, 4'd7},
    '{OP_I, LS, 32'd2, 4'd7},
    '{OP_R, HO, 32'hFFFFFFFE, 4'd7},   // own tick ignored
    '{OP_W, LC, 32'h09, 4'd7},
    '{OP_I, LS, 32'd2, 4'd7},
    '{OP_R, LO, 32'h0, 4'd7},
    '{OP_I, LS, 32'd1, 4'd7},
    '{OP_R, LO, 32'h2, 4'd7},
    '{OP_R, HO, 32'hFFFFFFFF, 4'd7},
    '{OP_R, ST, 32'h1, 4'd7},
    '{OP_P, LS, 32'h1, 4'd10},         // R10 low irq only
    '{OP_W, ST, 32'h1, 4'd9},
    '{OP_R, ST, 32'h0, 4'd9},
    '{OP_I, LS, 32'd2, 4'd8},
    '{OP_R, HO, 32'hFFFFFFFE, 4'd8},   // R8 overflow reload
    '{OP_R, ST, 32'h3, 4'd8},          // both flags same edge
    '{OP_P, LS, 32'h1, 4'd10},
    '{OP_W, IE, 32'h3, 4'd10},
    '{OP_P, LS, 32'h3, 4'd10},
    '{OP_I, LS, 32'd1, 4'd9},
    '{OP_W, ST, 32'h3, 4'd9},          // clear on low terminal edge
    '{OP_R, ST, 32'h1, 4'd9},          // R9 set wins
    '{OP_R, HO, 32'hFFFFFFFF, 4'd7},
    '{OP_P, LS, 32'h1, 4'd10},
    '{OP_W, LC, 32'h0, 4'd3},
    '{OP_W, HC, 32'h0, 4'd3},
    '{OP_W, ST, 32'h3, 4'd9},
    '{OP_P, LS, 32'h0, 4'd10},
    '{OP_W, IE, 32'h0, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  tmr_pair #(
    .LO_W(24), .HI_W(32), .DIV_FAST(D0), .DIV_K32(D1), .DIV_K1(D2), .DIV_SLOW(D3)
  ) i_tmr_pair (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp,
                       input int req, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // R5: cycles from a flag clear to the next flag = (setting+1)*divisor - 1
  task automatic rate_check(input logic [1:0] src, input logic [31:0] setv, input int exp_n);
    int n;
    logic [31:0] v;
    wr(LC, 32'h0);
    wr(LSRC, {30'd0, src});
    wr(LS, setv);
    wr(LC, 32'h3);
    wr(ST, 32'h3);
    n = 0;
    rd(ST, v);
    while (!v[0] && n < 500) begin @(negedge clk); n++; rd(ST, v); end
    wr(ST, 32'h1);
    n = 0;
    rd(ST, v);
    while (!v[0] && n < 500) begin @(negedge clk); n++; rd(ST, v); end
    check(32'(n), 32'(exp_n), 5, $sformatf("tick period for source %0d", src));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      check(v, 32'h0, 1, $sformatf("reset read addr %0d", a));
    end
    check({30'd0, irq_hi, irq_lo}, 32'h0, 1, "reset irq pins");

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        OP_W: wr(TBL[i].addr, TBL[i].val);
        OP_R: begin
          rd(TBL[i].addr, v);
          check(v, TBL[i].val, int'(TBL[i].req), $sformatf("vector %0d addr %0d", i, TBL[i].addr));
        end
        OP_I: repeat (int'(TBL[i].val)) @(negedge clk);
        default: check({30'd0, irq_hi, irq_lo}, TBL[i].val, int'(TBL[i].req),
                       $sformatf("vector %0d irq pins", i));
      endcase
    end

    // R5 rate selection
    rate_check(2'd1, 32'd1, 2 * D1 - 1);
    rate_check(2'd2, 32'd0, D2 - 1);
    rate_check(2'd3, 32'd0, D3 - 1);
    rate_check(2'd0, 32'd3, 4 * D0 - 1);

    // R1 reset while running
    wr(LSRC, 32'h0);
    wr(LS, 32'h7);
    wr(LC, 32'h3);
    wr(IE, 32'h1);
    repeat (10) @(negedge clk);
    check({31'd0, irq_lo}, 32'h1, 10, "irq before reset");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(LO, v); check(v, 32'h0, 1, "count after reset");
    rd(LS, v); check(v, 32'h0, 1, "setting after reset");
    rd(LC, v); check(v, 32'h0, 1, "control after reset");
    rd(ST, v); check(v, 32'h0, 1, "status after reset");
    check({30'd0, irq_hi, irq_lo}, 32'h0, 1, "irq after reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule